// File: doc/BRIEF.md
# Floating-Point Multiply-Add Systolic Cell

This block is the inner-product step element of a systolic array that triangulates matrices. Every cycle it can accept three floating-point operands `x`, `y` and `z` and, five cycles later, returns `w = x*y + z` rounded to the same format. Alongside `w` it hands `x` and `y` on unchanged to the next cells, with the same delay, so that a row of these cells can be chained without extra registers.

The word holds the sign in its most significant bit, then a biased exponent, then a fraction with an implicit leading one. The exponent and fraction widths are parameters, and the defaults give the usual 32-bit single format. The datapath runs in five stages. The first multiplies the mantissas and forms the product exponent. The second aligns the smaller term to the larger one. The third adds or subtracts. The fourth normalizes using a leading-zero count. The fifth rounds and handles special results. A static input selects round-to-nearest-even or truncation. Subnormal operands are treated as zero. Overflow, underflow and invalid operations each raise a flag of their own.

Top module: `fma_cell`

## Requirements
- R1: Word layout: the sign is bit W-1, the biased exponent (bias 2^(EXP_W-1)-1) is the next EXP_W bits, and the fraction is the low FRAC_W bits. An exponent field of 0 means zero, including inputs with a nonzero fraction. With `roundNearest`=1, `wOut` is the exact value of x*y+z rounded to nearest, ties to even.
- R2: With `roundNearest`=0, `wOut` is the exact value of x*y+z with all bits below the fraction's LSB discarded (rounding toward zero).
- R3: `outValid` is 0 after reset. It equals `inValid` delayed by exactly 5 clock cycles, and a new operand set may be presented on every cycle.
- R4: `xOut` and `yOut` equal the `xIn` and `yIn` that were presented 5 cycles earlier.
- R5: A NaN operand (exponent all ones, fraction nonzero), infinity times zero, or a sum of opposite-signed infinities gives the quiet NaN: sign 0, exponent all ones, fraction MSB 1, other bits 0. For the default widths this is 0x7FC00000. `invFlag`=1, and no other flag is raised.
- R6: Any other case with an infinite operand gives an infinity (exponent all ones, fraction 0). Its sign is the product's sign if x or y is infinite, otherwise the sign of z. No flag is raised.
- R7: When the rounded biased exponent reaches 2^EXP_W-1, the result is an infinity with the result's sign and `ovfFlag`=1.
- R8: When the rounded biased exponent is 0 or below, the result is a zero with the result's sign and `udfFlag`=1.
- R9: When both terms are zero, the result is a zero whose sign is the AND of the product sign and the sign of z. An exact cancellation of nonzero terms gives +0 in both modes. No flag is raised in either case.
- R10: A round-up that carries out of the mantissa gives fraction 0 and raises the exponent by one.
- R11: At most one of `ovfFlag`, `udfFlag` and `invFlag` is high with a valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operand set present this cycle |
| roundNearest | input | 1 | 1: nearest-even, 0: truncate (static) |
| xIn | input | W | Multiplicand |
| yIn | input | W | Multiplier |
| zIn | input | W | Addend |
| outValid | output | 1 | Result present |
| wOut | output | W | Rounded x*y+z |
| xOut | output | W | Forwarded x |
| yOut | output | W | Forwarded y |
| ovfFlag | output | 1 | Result overflowed to infinity |
| udfFlag | output | 1 | Result underflowed to zero |
| invFlag | output | 1 | Invalid operation, NaN returned |

## Verification
The bench builds the cell with EXP_W=4 and FRAC_W=3, an 8-bit word. At this size every pairing of x and y can be swept, with a pseudo-random z, in both rounding modes. That puts each special encoding, every subnormal input, exact cancellation, carries out of rounding and both range limits within reach. An exact integer model in the bench supplies the expected results. Idle cycles are inserted at regular gaps to exercise the valid pipeline.

// File: rtl/fma_pkg.sv
package fma_pkg;
  localparam int NSTAGE = 5;

  // per-stage load strobes from control to datapath
  typedef struct packed {
    logic [NSTAGE-1:0] load;
    logic              nearest;
  } fmaStrobe_t;

  // special-case outcome decided at the first stage
  typedef struct packed {
    logic inv;
    logic inf;
    logic infSign;
  } fmaSpecial_t;
endpackage

// File: rtl/fma_lzc.sv
module fma_lzc #(
  parameter int WIDTH = 52,
  localparam int NSLICE = (WIDTH + 7) / 8,
  localparam int PADW = NSLICE * 8,
  localparam int CW = $clog2(PADW + 1)
) (
  input  logic [WIDTH-1:0] vecIn,
  output logic [CW-1:0]    zeroCount
);
  function automatic logic [3:0] lz8(input logic [7:0] c);
    logic [3:0] n;
    n = 4'd8;
    for (int b = 0; b < 8; b++) if (c[b]) n = 4'(7 - b);
    return n;
  endfunction

  logic [PADW-1:0] padded;
  logic [3:0] sliceCnt [NSLICE];
  logic [NSLICE-1:0] sliceHit;

  assign padded = PADW'(vecIn) << (PADW - WIDTH);

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    logic [7:0] chunk;
    assign chunk = padded[PADW-1-8*s -: 8];
    assign sliceCnt[s] = lz8(chunk);
    assign sliceHit[s] = |chunk;
  end

  always_comb begin
    zeroCount = CW'(PADW);
    for (int s = NSLICE - 1; s >= 0; s--)
      if (sliceHit[s]) zeroCount = CW'(8 * s) + CW'(sliceCnt[s]);
  end
endmodule

// File: rtl/fma_ctrl.sv
module fma_ctrl
  import fma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       roundNearest,
  output fmaStrobe_t strobe,
  output logic       outValid
);
  logic [NSTAGE-1:0] stageValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageValid <= '0;
    else       stageValid <= {stageValid[NSTAGE-2:0], inValid};
  end

  assign strobe.load    = {stageValid[NSTAGE-2:0], inValid};
  assign strobe.nearest = roundNearest;
  assign outValid       = stageValid[NSTAGE-1];
endmodule

// File: rtl/fma_dp.sv
module fma_dp
  import fma_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int FRAC_W = 23,
  localparam int W = 1 + EXP_W + FRAC_W,
  localparam int M = FRAC_W + 1,
  localparam int PW = 2 * M,
  localparam int S = PW + 4,
  localparam int EW = EXP_W + 4,
  localparam int DW = $clog2(S + 1),
  localparam int CW = $clog2(((S + 7) / 8) * 8 + 1),
  localparam int BIAS = (1 << (EXP_W - 1)) - 1,
  localparam int EMAX = (1 << EXP_W) - 1
) (
  input  logic         clk,
  input  fmaStrobe_t   strobe,
  input  logic [W-1:0] xIn,
  input  logic [W-1:0] yIn,
  input  logic [W-1:0] zIn,
  output logic [W-1:0] wOut,
  output logic [W-1:0] xOut,
  output logic [W-1:0] yOut,
  output logic         ovfOut,
  output logic         udfOut,
  output logic         invOut
);
  // ---------------- stage 1: decode, multiply ----------------
  logic sx, sy, sz;
  logic [EXP_W-1:0] ex, ey, ez;
  logic [FRAC_W-1:0] fx, fy, fz;
  logic xNan, yNan, zNan, xInf, yInf, zInf, xZero, yZero, zZero;
  logic prodSign;
  logic [PW-1:0] prodMant;
  logic signed [EW-1:0] prodExp;
  fmaSpecial_t spNow;

  assign {sx, ex, fx} = xIn;
  assign {sy, ey, fy} = yIn;
  assign {sz, ez, fz} = zIn;
  assign xNan = (&ex) & (|fx);
  assign yNan = (&ey) & (|fy);
  assign zNan = (&ez) & (|fz);
  assign xInf = (&ex) & ~(|fx);
  assign yInf = (&ey) & ~(|fy);
  assign zInf = (&ez) & ~(|fz);
  assign xZero = ~(|ex);
  assign yZero = ~(|ey);
  assign zZero = ~(|ez);
  assign prodSign = sx ^ sy;
  assign prodMant = {{M{1'b0}}, 1'b1, fx} * {{M{1'b0}}, 1'b1, fy};
  assign prodExp = EW'(ex) + EW'(ey) - EW'(BIAS);
  assign spNow.inv = xNan | yNan | zNan | (xInf & yZero) | (yInf & xZero)
                   | ((xInf | yInf) & zInf & (prodSign != sz));
  assign spNow.inf = xInf | yInf | zInf;
  assign spNow.infSign = (xInf | yInf) ? prodSign : sz;

  logic [PW-1:0] s1Prod;
  logic signed [EW-1:0] s1ProdExp, s1ZExp;
  logic s1ProdSign, s1ProdZero, s1ZSign, s1ZZero;
  logic [M-1:0] s1ZMant;

  always_ff @(posedge clk) begin
    if (strobe.load[0]) begin
      s1Prod     <= prodMant;
      s1ProdExp  <= prodExp;
      s1ProdSign <= prodSign;
      s1ProdZero <= xZero | yZero;
      s1ZMant    <= {1'b1, fz};
      s1ZExp     <= EW'(ez);
      s1ZSign    <= sz;
      s1ZZero    <= zZero;
    end
  end

  // ---------------- stage 2: alignment shift ----------------
  logic [S-1:0] pExt, zExt, bigMag, smallMag, smallShift, lostMask;
  logic prodBig, smallZero, stickyAl;
  logic signed [EW-1:0] bigExp, smallExp, expDiff;
  logic [DW-1:0] shiftAmt;

  assign pExt = {1'b0, s1Prod, 3'b000};
  assign zExt = {2'b00, s1ZMant, {(M-1){1'b0}}, 3'b000};
  assign prodBig = s1ZZero | (!s1ProdZero && (s1ProdExp >= s1ZExp));
  assign bigMag   = prodBig ? pExt : zExt;
  assign smallMag = prodBig ? zExt : pExt;
  assign bigExp   = prodBig ? s1ProdExp : s1ZExp;
  assign smallExp = prodBig ? s1ZExp : s1ProdExp;
  assign smallZero = prodBig ? s1ZZero : s1ProdZero;
  assign expDiff = bigExp - smallExp;
  assign shiftAmt = (expDiff >= $signed(EW'(S))) ? DW'(S) : expDiff[DW-1:0];
  assign lostMask = ~({S{1'b1}} << shiftAmt);
  assign stickyAl = |(smallMag & lostMask);
  assign smallShift = (smallMag >> shiftAmt) | {{(S-1){1'b0}}, stickyAl};

  logic [S-1:0] s2Big, s2Small;
  logic signed [EW-1:0] s2Exp;
  logic s2BigSign, s2SmallSign, s2BothZero, s2ZeroSign;

  always_ff @(posedge clk) begin
    if (strobe.load[1]) begin
      s2Big       <= bigMag;
      s2Small     <= smallZero ? '0 : smallShift;
      s2Exp       <= bigExp;
      s2BigSign   <= prodBig ? s1ProdSign : s1ZSign;
      s2SmallSign <= prodBig ? s1ZSign : s1ProdSign;
      s2BothZero  <= s1ProdZero & s1ZZero;
      s2ZeroSign  <= s1ProdSign & s1ZSign;
    end
  end

  // ---------------- stage 3: add / subtract ----------------
  logic [S-1:0] sumMag;
  logic sumSign;

  always_comb begin
    if (s2BigSign == s2SmallSign) begin
      sumMag  = s2Big + s2Small;
      sumSign = s2BigSign;
    end else if (s2Big >= s2Small) begin
      sumMag  = s2Big - s2Small;
      sumSign = s2BigSign;
    end else begin
      sumMag  = s2Small - s2Big;
      sumSign = s2SmallSign;
    end
  end

  logic [S-1:0] s3Mag;
  logic signed [EW-1:0] s3Exp;
  logic s3Sign, s3BothZero, s3ZeroSign;

  always_ff @(posedge clk) begin
    if (strobe.load[2]) begin
      s3Mag      <= sumMag;
      s3Sign     <= sumSign;
      s3Exp      <= s2Exp;
      s3BothZero <= s2BothZero;
      s3ZeroSign <= s2ZeroSign;
    end
  end

  // ---------------- stage 4: normalization shift ----------------
  logic [CW-1:0] leadZeros;

  fma_lzc #(.WIDTH(S)) u_lzc (.vecIn(s3Mag), .zeroCount(leadZeros));

  logic [S-1:0] s4Norm;
  logic signed [EW-1:0] s4Exp;
  logic s4Sign, s4Cancel, s4BothZero, s4ZeroSign;

  always_ff @(posedge clk) begin
    if (strobe.load[3]) begin
      s4Norm     <= s3Mag << leadZeros;
      s4Exp      <= s3Exp + EW'(2) - EW'(leadZeros);
      s4Sign     <= s3Sign;
      s4Cancel   <= ~(|s3Mag);
      s4BothZero <= s3BothZero;
      s4ZeroSign <= s3ZeroSign;
    end
  end

  // ---------------- stage 5: round, range, specials ----------------
  fmaSpecial_t spPipe [NSTAGE-1];

  for (genvar k = 0; k < NSTAGE - 1; k++) begin : g_spPipe
    if (k == 0) begin : g_head
      always_ff @(posedge clk) if (strobe.load[0]) spPipe[0] <= spNow;
    end else begin : g_body
      always_ff @(posedge clk) if (strobe.load[k]) spPipe[k] <= spPipe[k-1];
    end
  end

  logic [M-1:0] mantTrunc;
  logic [M:0] mantRound;
  logic guardBit, stickyRnd, roundUp;
  logic signed [EW-1:0] expFinal;
  logic [W-1:0] wNext;
  logic ovfNext, udfNext, invNext;
  fmaSpecial_t spLast;

  assign spLast = spPipe[NSTAGE-2];
  assign mantTrunc = s4Norm[S-1 -: M];
  assign guardBit = s4Norm[S-1-M];
  assign stickyRnd = |s4Norm[S-2-M:0];
  assign roundUp = strobe.nearest & guardBit & (stickyRnd | mantTrunc[0]);
  assign mantRound = {1'b0, mantTrunc} + (M+1)'(roundUp);
  assign expFinal = s4Exp + EW'(mantRound[M]);

  always_comb begin
    ovfNext = 1'b0;
    udfNext = 1'b0;
    invNext = 1'b0;
    if (spLast.inv) begin
      wNext = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
      invNext = 1'b1;
    end else if (spLast.inf) begin
      wNext = {spLast.infSign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (s4BothZero) begin
      wNext = {s4ZeroSign, {(W-1){1'b0}}};
    end else if (s4Cancel) begin
      wNext = '0;
    end else if (expFinal >= $signed(EW'(EMAX))) begin
      wNext = {s4Sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      ovfNext = 1'b1;
    end else if (expFinal <= $signed(EW'(0))) begin
      wNext = {s4Sign, {(W-1){1'b0}}};
      udfNext = 1'b1;
    end else begin
      wNext = {s4Sign, expFinal[EXP_W-1:0], mantRound[FRAC_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.load[NSTAGE-1]) begin
      wOut   <= wNext;
      ovfOut <= ovfNext;
      udfOut <= udfNext;
      invOut <= invNext;
    end
  end

  // ---------------- operand forwarding ----------------
  logic [W-1:0] xPipe [NSTAGE];
  logic [W-1:0] yPipe [NSTAGE];

  for (genvar k = 0; k < NSTAGE; k++) begin : g_fwd
    if (k == 0) begin : g_head
      always_ff @(posedge clk) if (strobe.load[0]) begin
        xPipe[0] <= xIn;
        yPipe[0] <= yIn;
      end
    end else begin : g_body
      always_ff @(posedge clk) if (strobe.load[k]) begin
        xPipe[k] <= xPipe[k-1];
        yPipe[k] <= yPipe[k-1];
      end
    end
  end

  assign xOut = xPipe[NSTAGE-1];
  assign yOut = yPipe[NSTAGE-1];
endmodule

// File: rtl/fma_cell.sv
module fma_cell
  import fma_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic                    roundNearest,
  input  logic [EXP_W+FRAC_W:0]   xIn,
  input  logic [EXP_W+FRAC_W:0]   yIn,
  input  logic [EXP_W+FRAC_W:0]   zIn,
  output logic                    outValid,
  output logic [EXP_W+FRAC_W:0]   wOut,
  output logic [EXP_W+FRAC_W:0]   xOut,
  output logic [EXP_W+FRAC_W:0]   yOut,
  output logic                    ovfFlag,
  output logic                    udfFlag,
  output logic                    invFlag
);
  fmaStrobe_t strobe;

  fma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .roundNearest(roundNearest),
    .strobe(strobe), .outValid(outValid)
  );

  fma_dp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dp (
    .clk(clk), .strobe(strobe), .xIn(xIn), .yIn(yIn), .zIn(zIn),
    .wOut(wOut), .xOut(xOut), .yOut(yOut),
    .ovfOut(ovfFlag), .udfOut(udfFlag), .invOut(invFlag)
  );
endmodule

// File: rtl/fma_cell_chk.sv
module fma_cell_chk
  import fma_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int FRAC_W = 23,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic [W-1:0] xIn,
  input logic [W-1:0] yIn,
  input logic         outValid,
  input logic [W-1:0] wOut,
  input logic [W-1:0] xOut,
  input logic [W-1:0] yOut,
  input logic         ovfFlag,
  input logic         udfFlag,
  input logic         invFlag
);
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-2:0] INFMAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  logic [3:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 4'hF) sinceRst <= sinceRst + 4'd1;
  end

  // R3: valid emerges exactly five cycles after it enters
  p_latency_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 4'(NSTAGE)) |-> (outValid == $past(inValid, NSTAGE)));

  // R4: forwarded operands keep the same five-cycle delay
  p_forward_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 4'(NSTAGE) && outValid) |->
      (xOut == $past(xIn, NSTAGE) && yOut == $past(yIn, NSTAGE)));

  p_nan_code_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && invFlag) |-> (wOut == QNAN));

  p_ovf_inf_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && ovfFlag) |-> (wOut[W-2:0] == INFMAG));

  p_udf_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && udfFlag) |-> (wOut[W-2:0] == '0));

  p_one_flag_r11: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($countones({ovfFlag, udfFlag, invFlag}) <= 1));
endmodule

bind fma_cell fma_cell_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .xIn(xIn), .yIn(yIn),
  .outValid(outValid), .wOut(wOut), .xOut(xOut), .yOut(yOut),
  .ovfFlag(ovfFlag), .udfFlag(udfFlag), .invFlag(invFlag)
);

// File: tb/fma_cell_tb.sv
module fma_cell_tb;
  localparam int EXP_W = 4;
  localparam int FRAC_W = 3;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic roundNearest = 1'b1;
  logic [W-1:0] xIn = '0, yIn = '0, zIn = '0;
  logic outValid, ovfFlag, udfFlag, invFlag;
  logic [W-1:0] wOut, xOut, yOut;

  int testsRun = 0;
  int testsFailed = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fma_cell #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .roundNearest(roundNearest),
    .xIn(xIn), .yIn(yIn), .zIn(zIn), .outValid(outValid), .wOut(wOut),
    .xOut(xOut), .yOut(yOut), .ovfFlag(ovfFlag), .udfFlag(udfFlag), .invFlag(invFlag)
  );

  typedef struct {
    logic [7:0] w, x, y, z;
    bit ovf, udf, inv;
    int stamp;
    string tag;
  } expect_t;

  expect_t pending[$];

  // exact reference: integer significands on a common binary scale
  function automatic void refModel(input logic [7:0] x, y, z, input bit rne,
                                   output logic [7:0] w, output bit ovf, udf, inv,
                                   output string tag);
    bit sx, sy, sz, sp, xN, yN, zN, xI, yI, zI, xZ, yZ, zZ, neg;
    int ex, ey, ez, fx, fy, fz, pe, ze, lo, k, e, be, sh;
    longint pm, zm, n, mag, mant, rem, half;
    sx = x[7]; ex = int'(x[6:3]); fx = int'(x[2:0]);
    sy = y[7]; ey = int'(y[6:3]); fy = int'(y[2:0]);
    sz = z[7]; ez = int'(z[6:3]); fz = int'(z[2:0]);
    xN = (ex == 15) && (fx != 0); yN = (ey == 15) && (fy != 0); zN = (ez == 15) && (fz != 0);
    xI = (ex == 15) && (fx == 0); yI = (ey == 15) && (fy == 0); zI = (ez == 15) && (fz == 0);
    xZ = (ex == 0); yZ = (ey == 0); zZ = (ez == 0);
    sp = sx ^ sy;
    ovf = 0; udf = 0; inv = 0;
    if (xN || yN || zN || (xI && yZ) || (yI && xZ) || ((xI || yI) && zI && (sp != sz))) begin
      w = 8'h7C; inv = 1; tag = "R5"; return;
    end
    if (xI || yI) begin w = {sp, 4'hF, 3'b000}; tag = "R6"; return; end
    if (zI) begin w = {sz, 4'hF, 3'b000}; tag = "R6"; return; end
    if ((xZ || yZ) && zZ) begin w = {sp & sz, 7'b0}; tag = "R9"; return; end
    pm = (8 + fx) * (8 + fy); pe = ex + ey - 20;
    zm = 8 + fz; ze = ez - 10;
    if (xZ || yZ) lo = ze;
    else if (zZ) lo = pe;
    else lo = (pe < ze) ? pe : ze;
    n = 0;
    if (!(xZ || yZ)) n += (sp ? -pm : pm) <<< (pe - lo);
    if (!zZ) n += (sz ? -zm : zm) <<< (ze - lo);
    if (n == 0) begin w = 8'h00; tag = "R9"; return; end
    neg = (n < 0);
    mag = neg ? -n : n;
    k = 0;
    for (int i = 0; i < 62; i++) if (((mag >> i) & 64'd1) != 0) k = i;
    e = k + lo;
    tag = rne ? "R1" : "R2";
    if (k > 3) begin
      sh = k - 3;
      mant = mag >> sh;
      rem = mag & ((64'd1 << sh) - 1);
      half = 64'd1 << (sh - 1);
      if (rne && ((rem > half) || (rem == half && mant[0]))) mant++;
      if (mant == 16) begin mant = 8; e++; tag = "R10"; end
    end else begin
      mant = mag << (3 - k);
    end
    be = e + 7;
    if (be >= 15) begin w = {neg, 4'hF, 3'b000}; ovf = 1; tag = "R7"; end
    else if (be <= 0) begin w = {neg, 7'b0}; udf = 1; tag = "R8"; end
    else w = {neg, be[3:0], mant[2:0]};
  endfunction

  task automatic report(input bit ok, input string tag, input string msg);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s cycle %0d: %s", tag, cyc, msg);
    end
  endtask

  // compare outputs at a falling edge against the oldest pending result
  task automatic checkOutputs();
    expect_t ex;
    if (!outValid) return;
    if (pending.size() == 0) begin
      report(0, "R3", "outValid high, expected no result in flight");
      return;
    end
    ex = pending.pop_front();
    report(cyc - ex.stamp == 5, "R3",
           $sformatf("latency actual %0d expected 5", cyc - ex.stamp));
    report(xOut == ex.x && yOut == ex.y, "R4",
           $sformatf("fwd actual x=%h y=%h expected x=%h y=%h", xOut, yOut, ex.x, ex.y));
    report(wOut == ex.w && ovfFlag == ex.ovf && udfFlag == ex.udf && invFlag == ex.inv,
           ex.tag,
           $sformatf("x=%h y=%h z=%h mode=%0d actual w=%h o/u/i=%0d%0d%0d expected w=%h o/u/i=%0d%0d%0d",
                     ex.x, ex.y, ex.z, roundNearest, wOut, ovfFlag, udfFlag, invFlag,
                     ex.w, ex.ovf, ex.udf, ex.inv));
  endtask

  task automatic tick(input bit v, input logic [7:0] x, y, z);
    expect_t ex;
    @(negedge clk);
    cyc++;
    checkOutputs();
    inValid = v; xIn = x; yIn = y; zIn = z;
    if (v) begin
      refModel(x, y, z, roundNearest, ex.w, ex.ovf, ex.udf, ex.inv, ex.tag);
      ex.x = x; ex.y = y; ex.z = z; ex.stamp = cyc;
      pending.push_back(ex);
    end
  endtask

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    report(outValid == 1'b0, "R3", $sformatf("reset outValid actual %0d expected 0", outValid));
    rstN = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick(0, 8'h00, 8'h00, 8'h00);
      report(outValid == 1'b0, "R3", $sformatf("idle outValid actual %0d expected 0", outValid));
    end
    for (int mode = 1; mode >= 0; mode--) begin
      roundNearest = mode[0];
      for (int xi = 0; xi < 256; xi++) begin
        for (int yi = 0; yi < 256; yi++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          tick(1, 8'(xi), 8'(yi), lfsr[7:0]);
          if ((yi & 15) == 15) tick(0, 8'h00, 8'h00, 8'h00);
        end
      end
      for (int i = 0; i < 8; i++) tick(0, 8'h00, 8'h00, 8'h00);
      report(pending.size() == 0, "R3",
             $sformatf("results outstanding actual %0d expected 0", pending.size()));
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL R3 watchdog expired at cycle %0d, expected sweep to complete", cyc);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule